// File: doc/BRIEF.md
# Stack and Port Instruction Sequencer

This block is a small multicycle execution unit for four instructions of an 8-bit accumulator machine. It keeps the accumulator A, the register pair H:L and the 16-bit stack pointer SP. It runs four operations: swapping H:L with the two bytes at the top of the stack, copying H:L into SP, reading a byte from an I/O port into A, and writing A to an I/O port. Each operation drives a simple single-cycle memory/port bus in a fixed cycle pattern and lasts an exact number of clock states.

An instruction is issued by raising `start` for one clock while the unit is idle. The instruction is given as an already fetched opcode byte plus the immediate port byte. The unit then stays busy for the full state count of that instruction. It raises `done` in its final state, and its register outputs show the result from the following cycle. Instruction fetch, flags and interrupts are handled elsewhere.

Top module: `stack_port_seq`

## Requirements
- R1: After reset, A, H, L and SP read 0000h/00h, `busy` and `done` are low, and no bus strobe or `io_sel` is active.
- R2: A `start` seen while idle with opcode E3h, F9h, DBh or D3h makes `busy` high for exactly 18, 5, 10 or 10 clock cycles. The first of these cycles is state 1, directly after the accepting edge. `done` is high only in the last one.
- R3: `start` is ignored while `busy` is high. A `start` with any other opcode is also ignored: `busy` stays low and no register or bus output changes.
- R4: E3h (exchange with stack top) reads address SP in state 6 and SP+1 in state 9. It writes the old H to SP+1 in state 12 and the old L to SP in state 16. Afterwards L holds the old byte at SP, H holds the old byte at SP+1, and SP and A are unchanged.
- R5: The address SP+1 is computed modulo 2^16, so SP = FFFFh gives 0000h.
- R6: F9h loads SP with {H, L}, with H as the high byte. It makes no bus access, and SP changes at no other time.
- R7: DBh (port input) makes one read in state 9 with `io_sel` high and the port byte on both halves of `mem_addr`. A then takes the value on `mem_rdata` in that state.
- R8: D3h (port output) makes one write in state 9 with `io_sel` high, the port byte on both address halves and A on `mem_wdata`. No register changes.
- R9: `mem_rd` and `mem_wr` are never high together. Each is a single-cycle pulse that occurs only while `busy` is high. `io_sel` is high only during a strobe, and it is low for every memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Issue request, sampled while idle |
| opcode | input | 8 | Decoded opcode byte of the issued instruction |
| port_num | input | 8 | Immediate port byte, sampled with `start` |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_rd` is high |
| busy | output | 1 | An instruction is executing |
| done | output | 1 | Final state of the executing instruction |
| mem_addr | output | 16 | Memory address, or the port byte doubled for I/O |
| mem_wdata | output | 8 | Write data, valid while `mem_wr` is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| io_sel | output | 1 | Strobe addresses the port space instead of memory |
| a_q | output | 8 | Accumulator |
| h_q | output | 8 | H register |
| l_q | output | 8 | L register |
| sp_q | output | 16 | Stack pointer |

## Verification
The bound checker watches every cycle for the bus rules: exclusive single-cycle strobes, strobes only while busy, `io_sel` only with a strobe, and the port byte doubled on the address. It also checks that `done` is a lone pulse inside `busy` and that SP moves only at the end of an instruction. The exact state in which each strobe fires, the total state count per opcode, the exchanged byte values, the address wrap at FFFFh and the rejection of unknown opcodes or of a request made while busy depend on data and history. Only the bench's directed and random instruction streams, compared against its own model, can show these.

// File: rtl/sps_pkg.sv
package sps_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2 * DATA_W;

  localparam logic [DATA_W-1:0] OPC_XCHG = 8'hE3;
  localparam logic [DATA_W-1:0] OPC_SPLD = 8'hF9;
  localparam logic [DATA_W-1:0] OPC_PIN  = 8'hDB;
  localparam logic [DATA_W-1:0] OPC_POUT = 8'hD3;

  localparam int unsigned XCHG_STATES = 18;
  localparam int unsigned SPLD_STATES = 5;
  localparam int unsigned PORT_STATES = 10;

  localparam int unsigned XCHG_RD_LO = 6;
  localparam int unsigned XCHG_RD_HI = 9;
  localparam int unsigned XCHG_WR_HI = 12;
  localparam int unsigned XCHG_WR_LO = 16;
  localparam int unsigned PORT_ACC   = 9;

  localparam int unsigned CNT_W = $clog2(XCHG_STATES + 1);

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_XCHG = 3'd1,
    K_SPLD = 3'd2,
    K_PIN  = 3'd3,
    K_POUT = 3'd4
  } op_kind_t;

  function automatic op_kind_t decode_op(input logic [DATA_W-1:0] opc);
    op_kind_t k;
    case (opc)
      OPC_XCHG: k = K_XCHG;
      OPC_SPLD: k = K_SPLD;
      OPC_PIN:  k = K_PIN;
      OPC_POUT: k = K_POUT;
      default:  k = K_NONE;
    endcase
    return k;
  endfunction

  function automatic logic [CNT_W-1:0] last_state(input op_kind_t k);
    logic [CNT_W-1:0] n;
    case (k)
      K_XCHG:        n = CNT_W'(XCHG_STATES);
      K_SPLD:        n = CNT_W'(SPLD_STATES);
      K_PIN, K_POUT: n = CNT_W'(PORT_STATES);
      default:       n = CNT_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sps_rst_sync.sv
module sps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/sps_sequencer.sv
module sps_sequencer
  import sps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DATA_W-1:0]     opcode,
  input  logic [DATA_W-1:0]     port_num,
  output logic                  busy,
  output logic                  done,
  output op_kind_t              op,
  output logic [CNT_W-1:0]      cnt,
  output logic [DATA_W-1:0]     port_q
);

  logic              busy_q, busy_d;
  op_kind_t          op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] port_d;
  op_kind_t          req_kind;
  logic              accept;
  logic              at_last;

  assign req_kind = decode_op(opcode);
  assign accept   = !busy_q && start && (req_kind != K_NONE);
  assign at_last  = busy_q && (cnt_q == last_state(op_q));

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    cnt_d  = cnt_q;
    port_d = port_q;
    if (accept) begin
      busy_d = 1'b1;
      op_d   = req_kind;
      cnt_d  = CNT_W'(1);
      port_d = port_num;
    end else if (at_last) begin
      busy_d = 1'b0;
      op_d   = K_NONE;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= K_NONE;
      cnt_q  <= '0;
      port_q <= '0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      port_q <= port_d;
    end
  end

  assign busy = busy_q;
  assign done = at_last;
  assign op   = op_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/sps_bus_plan.sv
module sps_bus_plan
  import sps_pkg::*;
(
  input  op_kind_t              op,
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  done,
  input  logic [DATA_W-1:0]     port_q,
  input  logic [DATA_W-1:0]     a_q,
  input  logic [DATA_W-1:0]     h_q,
  input  logic [DATA_W-1:0]     l_q,
  input  logic [ADDR_W-1:0]     sp_q,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  io_sel,
  output logic                  ld_tlo,
  output logic                  ld_thi,
  output logic                  ld_h,
  output logic                  ld_l,
  output logic                  ld_a,
  output logic                  ld_sp
);

  logic [ADDR_W-1:0] sp_inc;
  logic              s_rd_lo, s_rd_hi, s_wr_hi, s_wr_lo, s_port;

  // Adder width equals the address width, so FFFFh + 1 wraps to 0000h.
  assign sp_inc = sp_q + ADDR_W'(1);

  assign s_rd_lo = (cnt == CNT_W'(XCHG_RD_LO));
  assign s_rd_hi = (cnt == CNT_W'(XCHG_RD_HI));
  assign s_wr_hi = (cnt == CNT_W'(XCHG_WR_HI));
  assign s_wr_lo = (cnt == CNT_W'(XCHG_WR_LO));
  assign s_port  = (cnt == CNT_W'(PORT_ACC));

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    io_sel    = 1'b0;
    ld_tlo    = 1'b0;
    ld_thi    = 1'b0;
    ld_h      = 1'b0;
    ld_l      = 1'b0;
    ld_a      = 1'b0;
    ld_sp     = 1'b0;
    case (op)
      K_XCHG: begin
        if (s_rd_lo) begin
          mem_addr = sp_q;
          mem_rd   = 1'b1;
          ld_tlo   = 1'b1;
        end else if (s_rd_hi) begin
          mem_addr = sp_inc;
          mem_rd   = 1'b1;
          ld_thi   = 1'b1;
        end else if (s_wr_hi) begin
          mem_addr  = sp_inc;
          mem_wdata = h_q;
          mem_wr    = 1'b1;
          ld_h      = 1'b1;
        end else if (s_wr_lo) begin
          mem_addr  = sp_q;
          mem_wdata = l_q;
          mem_wr    = 1'b1;
          ld_l      = 1'b1;
        end
      end
      K_SPLD: begin
        ld_sp = done;
      end
      K_PIN: begin
        if (s_port) begin
          mem_addr = {port_q, port_q};
          mem_rd   = 1'b1;
          io_sel   = 1'b1;
          ld_a     = 1'b1;
        end
      end
      K_POUT: begin
        if (s_port) begin
          mem_addr  = {port_q, port_q};
          mem_wdata = a_q;
          mem_wr    = 1'b1;
          io_sel    = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/sps_regs.sv
module sps_regs
  import sps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ld_tlo,
  input  logic              ld_thi,
  input  logic              ld_h,
  input  logic              ld_l,
  input  logic              ld_a,
  input  logic              ld_sp,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] h_q,
  output logic [DATA_W-1:0] l_q,
  output logic [ADDR_W-1:0] sp_q
);

  logic [DATA_W-1:0] tlo_q, thi_q;
  logic [DATA_W-1:0] a_d, h_d, l_d, tlo_d, thi_d;
  logic [ADDR_W-1:0] sp_d;

  always_comb begin
    a_d   = ld_a   ? mem_rdata : a_q;
    tlo_d = ld_tlo ? mem_rdata : tlo_q;
    thi_d = ld_thi ? mem_rdata : thi_q;
    h_d   = ld_h   ? thi_q     : h_q;
    l_d   = ld_l   ? tlo_q     : l_q;
    sp_d  = ld_sp  ? {h_q, l_q} : sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      h_q   <= '0;
      l_q   <= '0;
      sp_q  <= '0;
      tlo_q <= '0;
      thi_q <= '0;
    end else begin
      a_q   <= a_d;
      h_q   <= h_d;
      l_q   <= l_d;
      sp_q  <= sp_d;
      tlo_q <= tlo_d;
      thi_q <= thi_d;
    end
  end

endmodule

// File: rtl/stack_port_seq.sv
module stack_port_seq
  import sps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  port_num,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        io_sel,
  output logic [7:0]  a_q,
  output logic [7:0]  h_q,
  output logic [7:0]  l_q,
  output logic [15:0] sp_q
);

  logic              rst_sync_n;
  op_kind_t          op;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] port_q;
  logic              ld_tlo, ld_thi, ld_h, ld_l, ld_a, ld_sp;

  sps_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sps_sequencer i_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .opcode   (opcode),
    .port_num (port_num),
    .busy     (busy),
    .done     (done),
    .op       (op),
    .cnt      (cnt),
    .port_q   (port_q)
  );

  sps_bus_plan i_plan (
    .op        (op),
    .cnt       (cnt),
    .done      (done),
    .port_q    (port_q),
    .a_q       (a_q),
    .h_q       (h_q),
    .l_q       (l_q),
    .sp_q      (sp_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_sel    (io_sel),
    .ld_tlo    (ld_tlo),
    .ld_thi    (ld_thi),
    .ld_h      (ld_h),
    .ld_l      (ld_l),
    .ld_a      (ld_a),
    .ld_sp     (ld_sp)
  );

  sps_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mem_rdata (mem_rdata),
    .ld_tlo    (ld_tlo),
    .ld_thi    (ld_thi),
    .ld_h      (ld_h),
    .ld_l      (ld_l),
    .ld_a      (ld_a),
    .ld_sp     (ld_sp),
    .a_q       (a_q),
    .h_q       (h_q),
    .l_q       (l_q),
    .sp_q      (sp_q)
  );

endmodule

// File: rtl/stack_port_seq_chk.sv
module stack_port_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        io_sel,
  input logic [15:0] mem_addr,
  input logic [15:0] sp_q
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9

  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy); // R9

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R9

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr); // R9

  AST_IO_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (mem_rd || mem_wr)); // R9

  AST_PORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (mem_addr[15:8] == mem_addr[7:0])); // R7

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_SP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(sp_q)); // R6

endmodule

bind stack_port_seq stack_port_seq_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .io_sel   (io_sel),
  .mem_addr (mem_addr),
  .sp_q     (sp_q)
);

// File: tb/test_stack_port_seq.sv
module test_stack_port_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic [7:0]  port_num;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rd, mem_wr, io_sel;
  logic [7:0]  a_q, h_q, l_q;
  logic [15:0] sp_q;

  int n_tests;
  int n_fail;
  bit finished;

  logic [7:0] mem [0:4095];

  stack_port_seq i_stack_port_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .port_num(port_num), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_sel(io_sel), .a_q(a_q), .h_q(h_q), .l_q(l_q),
    .sp_q(sp_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] port_byte(input logic [7:0] p);
    return {p[3:0], p[7:4]} ^ 8'hC3;
  endfunction

  always_comb begin
    if (io_sel) mem_rdata = port_byte(mem_addr[7:0]);
    else        mem_rdata = mem[mem_addr[11:0]];
  end

  always @(posedge clk) begin
    if (mem_wr && !io_sel) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // observed bus events of one instruction
  int          ev_n;
  int          ev_k   [0:7];
  bit          ev_wr  [0:7];
  bit          ev_io  [0:7];
  logic [15:0] ev_addr[0:7];
  logic [7:0]  ev_wd  [0:7];
  int          n_states;
  bit          gap_seen;
  bit          early_done;

  task automatic run_op(input logic [7:0] opc, input logic [7:0] p, input bit hold);
    bit fin;
    int k;
    @(negedge clk);
    start = 1'b1; opcode = opc; port_num = p;
    ev_n = 0; k = 0; fin = 0; gap_seen = 0; early_done = 0;
    while (k < 40 && !fin) begin
      @(negedge clk);
      k++;
      if (!hold) start = 1'b0;
      else if (k == 2) begin opcode = 8'hF9; port_num = ~p; end
      if (!busy) gap_seen = 1;
      if ((mem_rd || mem_wr) && ev_n < 8) begin
        ev_k[ev_n] = k; ev_wr[ev_n] = mem_wr; ev_io[ev_n] = io_sel;
        ev_addr[ev_n] = mem_addr; ev_wd[ev_n] = mem_wdata;
        ev_n++;
      end
      if (done) fin = 1;
    end
    start = 1'b0;
    n_states = fin ? k : -1;
  endtask

  task automatic chk_ev(input int i, input int k, input bit wr, input bit io,
                        input logic [15:0] addr, input logic [7:0] wd, input string req);
    chk(ev_k[i] == k, req, "strobe state", ev_k[i], k);
    chk(ev_wr[i] == wr && ev_io[i] == io, req, "strobe kind {wr,io}",
        {ev_wr[i], ev_io[i]}, {wr, io});
    chk(ev_addr[i] == addr, req, "strobe address", ev_addr[i], addr);
    if (wr) chk(ev_wd[i] == wd, req, "write data", ev_wd[i], wd);
  endtask

  // issue one instruction and check it against the bench model
  task automatic exec(input logic [7:0] opc, input logic [7:0] p, input bit hold);
    logic [7:0]  pa, ph, pl, m_lo, m_hi;
    logic [15:0] psp, sp1;
    int          exp_n;
    pa = a_q; ph = h_q; pl = l_q; psp = sp_q;
    sp1 = psp + 16'd1;
    m_lo = mem[psp[11:0]]; m_hi = mem[sp1[11:0]];
    run_op(opc, p, hold);
    case (opc)
      8'hE3: exp_n = 18;
      8'hF9: exp_n = 5;
      default: exp_n = 10;
    endcase
    chk(n_states == exp_n, "R2", "state count", n_states, exp_n);
    chk(!gap_seen, "R2", "busy held every state", gap_seen, 0);
    if (hold) chk(n_states == exp_n, "R3", "start while busy ignored", n_states, exp_n);
    @(negedge clk);
    chk(!busy && !done, "R2", "idle after done", {busy, done}, 0);
    case (opc)
      8'hE3: begin
        chk(ev_n == 4, "R4", "strobe count", ev_n, 4);
        if (ev_n == 4) begin
          chk_ev(0, 6,  0, 0, psp, 8'h00, "R4");
          chk_ev(1, 9,  0, 0, sp1, 8'h00, "R5");
          chk_ev(2, 12, 1, 0, sp1, ph,    "R5");
          chk_ev(3, 16, 1, 0, psp, pl,    "R4");
        end
        chk(l_q == m_lo && h_q == m_hi, "R4", "H:L after exchange",
            {h_q, l_q}, {m_hi, m_lo});
        chk(mem[psp[11:0]] == pl && mem[sp1[11:0]] == ph, "R4", "stack bytes",
            {mem[sp1[11:0]], mem[psp[11:0]]}, {ph, pl});
        chk(sp_q == psp && a_q == pa, "R4", "SP and A kept", {sp_q, a_q}, {psp, pa});
      end
      8'hF9: begin
        chk(ev_n == 0, "R6", "no bus access", ev_n, 0);
        chk(sp_q == {ph, pl}, "R6", "SP loaded", sp_q, {ph, pl});
        chk(a_q == pa && h_q == ph && l_q == pl, "R6", "other regs kept",
            {a_q, h_q, l_q}, {pa, ph, pl});
      end
      8'hDB: begin
        chk(ev_n == 1, "R7", "strobe count", ev_n, 1);
        if (ev_n == 1) chk_ev(0, 9, 0, 1, {p, p}, 8'h00, "R7");
        chk(a_q == port_byte(p), "R7", "A from port", a_q, port_byte(p));
        chk(sp_q == psp && h_q == ph && l_q == pl, "R7", "other regs kept",
            {sp_q, h_q, l_q}, {psp, ph, pl});
      end
      default: begin
        chk(ev_n == 1, "R8", "strobe count", ev_n, 1);
        if (ev_n == 1) chk_ev(0, 9, 1, 1, {p, p}, pa, "R8");
        chk(a_q == pa && sp_q == psp && h_q == ph && l_q == pl, "R8", "regs kept",
            {a_q, sp_q, h_q, l_q}, {pa, psp, ph, pl});
      end
    endcase
  endtask

  task automatic try_illegal(input logic [7:0] opc);
    logic [7:0]  pa, ph, pl;
    logic [15:0] psp;
    bit          act;
    pa = a_q; ph = h_q; pl = l_q; psp = sp_q;
    @(negedge clk);
    start = 1'b1; opcode = opc; port_num = 8'h55;
    act = 0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy || done || mem_rd || mem_wr || io_sel) act = 1;
      @(negedge clk);
    end
    chk(!act, "R3", "unknown opcode ignored", act, 0);
    chk(a_q == pa && h_q == ph && l_q == pl && sp_q == psp, "R3",
        "regs after unknown opcode", {a_q, h_q, l_q, sp_q}, {pa, ph, pl, psp});
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 0;
    void'($urandom(32'd20240517));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    start = 0; opcode = 0; port_num = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(a_q == 0 && h_q == 0 && l_q == 0, "R1", "A,H,L reset", {a_q, h_q, l_q}, 0);
    chk(sp_q == 0, "R1", "SP reset", sp_q, 0);
    chk(!busy && !done && !mem_rd && !mem_wr && !io_sel, "R1", "control idle",
        {busy, done, mem_rd, mem_wr, io_sel}, 0);

    // directed: load H:L = FFFFh from stack at 0, then SP wrap case (R5)
    mem[0] = 8'hFF; mem[1] = 8'hFF;
    exec(8'hE3, 8'h00, 0);
    exec(8'hF9, 8'h00, 0);
    chk(sp_q == 16'hFFFF, "R5", "SP at top", sp_q, 16'hFFFF);
    exec(8'hE3, 8'h00, 0);
    exec(8'hDB, 8'h00, 0);
    exec(8'hDB, 8'hFF, 0);
    exec(8'hD3, 8'hA5, 0);
    exec(8'hE3, 8'h00, 1);   // start held high and altered while busy (R3)
    try_illegal(8'h00);
    try_illegal(8'hE2);
    exec(8'hF9, 8'h00, 1);

    // constrained random stream
    for (int n = 0; n < 120; n++) begin
      int sel;
      logic [7:0] opc;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1, 2: opc = 8'hE3;
        3, 4:    opc = 8'hF9;
        5, 6:    opc = 8'hDB;
        7, 8:    opc = 8'hD3;
        default: opc = 8'($urandom);
      endcase
      if (opc == 8'hE3 || opc == 8'hF9 || opc == 8'hDB || opc == 8'hD3)
        exec(opc, 8'($urandom), bit'($urandom_range(0, 3) == 0));
      else
        try_illegal(opc);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule